// File: doc/BRIEF.md
# Virtual Address Range Fault Checker

This block sits at the front of a 64-bit address translation unit. It screens each request before any table walk starts. From the virtual address, the requesting exception level and the translation-control fields, it decides which of two translation-table base regions serves the address. It then works out the effective input address size for that region. A fault is raised when that size is illegal for the region's granule, when the address bits above the size are not a proper extension of the region-select bit, or when the rules of the exception level forbid a walk through the chosen region.

For each request the block also reports the selected region, that region's granule code, its hierarchical-permission-disable bit and whether its inner cacheability marks the walk as uncacheable. The position of the region-select bit is an input (`req_top_bit`). It is normally 55 when the top address byte is used as a tag and 63 otherwise. The upstream logic that chooses this value is not part of the block.

All results are registered. They appear one clock after a request is presented with `req_valid` high, and they hold their value until the next request.

Top module: `va_range_checker`

## Requirements
- R1: The selected region is bit `req_top_bit` of `req_vaddr`: 0 selects region 0 (fields prefixed t0_), 1 selects region 1 (fields prefixed t1_). It is reported on `rsp_region`.
- R2: The input size is 64 minus the selected region's 6-bit size field, and it is not clamped. Granule codes are 0 = 4KB, 1 = 16KB, 2 = 64KB and 3 = reserved, which uses the 4KB limits. The maximum size is 52 when `large_va` is set and the granule is 64KB, and 48 in every other case. The minimum size is 17 for 64KB and 16 otherwise. A size outside these limits faults.
- R3: Every address bit from `req_top_bit` down to the input size must be 0 in region 0 and 1 in region 1, or the request faults. This holds for both `req_top_bit` = 55 and 63, and bits above `req_top_bit` are ignored.
- R4: At EL0 and EL1 (`req_el` 0 and 1), the selected region faults when its walk-disable bit is set.
- R5: At EL2, region 0 faults on `t0_walk_off` only while `host_ext` is set. Region 1 faults when `host_ext` is clear or `t1_walk_off` is set.
- R6: `rsp_hier_off` is the selected region's bit at EL0 and EL1, and at EL2 for region 1. At EL2, region 0 reports `t0_hier_off` when `host_ext` is set and `hier_off` otherwise. At EL3, region 0 reports `hier_off`.
- R7: At EL3 only region 0 exists. A region-1 address always faults, and it reports `rsp_gran`, `rsp_hier_off` and `rsp_uncached` as 0.
- R8: Except in the R7 case, `rsp_gran` is the selected region's granule code, and `rsp_uncached` is 1 exactly when the region's 2-bit inner-cacheability field is 0.
- R9: `rsp_valid` is high in the cycle after a cycle with `req_valid` high and low otherwise. The other outputs update only on a request and otherwise hold. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_el | input | 2 | Exception level 0..3 |
| req_top_bit | input | 6 | Position of the region-select bit (55 or 63) |
| t0_size | input | 6 | Region 0 size field |
| t1_size | input | 6 | Region 1 size field |
| t0_gran | input | 2 | Region 0 granule code |
| t1_gran | input | 2 | Region 1 granule code |
| t0_walk_off | input | 1 | Region 0 walk disable |
| t1_walk_off | input | 1 | Region 1 walk disable |
| t0_hier_off | input | 1 | Region 0 hierarchical-permission disable |
| t1_hier_off | input | 1 | Region 1 hierarchical-permission disable |
| hier_off | input | 1 | Single-region hierarchical-permission disable (EL2 without host extension, EL3) |
| t0_inner | input | 2 | Region 0 inner cacheability |
| t1_inner | input | 2 | Region 1 inner cacheability |
| host_ext | input | 1 | Host extension enabled (EL2 rules) |
| large_va | input | 1 | Large virtual address feature present |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Request faults |
| rsp_region | output | 1 | Selected region |
| rsp_gran | output | 2 | Granule code of the selected region |
| rsp_hier_off | output | 1 | Hierarchical-permission disable in effect |
| rsp_uncached | output | 1 | Walk is uncacheable |

## Verification
Every result is due exactly one clock after the edge that samples `req_valid`. The bench drives a request on a falling edge and removes it on the next falling edge. It then reads all outputs there, half a cycle after the registering edge, and compares them with a model evaluated on the same held inputs. The hold check changes the inputs with `req_valid` low, waits one more full cycle, and expects `rsp_valid` low and the earlier result unchanged.

// File: rtl/vafc_pkg.sv
package vafc_pkg;
  localparam int VA_W      = 64;
  localparam int TB_W      = $clog2(VA_W);
  localparam int SZ_W      = TB_W + 1;
  localparam int MAX_STD   = 48;
  localparam int MAX_LARGE = 52;
  localparam int MIN_SMALL = VA_W - 48;
  localparam int MIN_BIG   = VA_W - 47;

  localparam logic [1:0] GRAN_4K  = 2'd0;
  localparam logic [1:0] GRAN_16K = 2'd1;
  localparam logic [1:0] GRAN_64K = 2'd2;

  typedef struct packed {
    logic       fault;
    logic       region;
    logic [1:0] gran;
    logic       hier_off;
    logic       uncached;
  } vafc_rsp_t;
endpackage

// File: rtl/vafc_size_check.sv
module vafc_size_check
  import vafc_pkg::*;
#(
  parameter int ADDR_W = VA_W,
  localparam int IDX_W = $clog2(ADDR_W),
  localparam int SIZ_W = IDX_W + 1
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [IDX_W-1:0]  top_bit,
  input  logic [IDX_W-1:0]  size_field,
  input  logic [1:0]        gran,
  input  logic              large_va,
  input  logic              upper,
  output logic              addr_bad
);
  logic [SIZ_W-1:0]  in_size;
  logic [SIZ_W-1:0]  size_max;
  logic [SIZ_W-1:0]  size_min;
  logic              range_bad;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] mismatch;

  assign in_size  = SIZ_W'(ADDR_W) - {1'b0, size_field};
  assign size_max = (large_va && gran == GRAN_64K) ? SIZ_W'(MAX_LARGE) : SIZ_W'(MAX_STD);
  assign size_min = (gran == GRAN_64K) ? SIZ_W'(MIN_BIG) : SIZ_W'(MIN_SMALL);
  assign range_bad = (in_size > size_max) || (in_size < size_min);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_span
    assign span[i]     = (in_size <= SIZ_W'(i)) && ({1'b0, top_bit} >= SIZ_W'(i));
    assign mismatch[i] = span[i] & (vaddr[i] ^ upper);
  end

  assign addr_bad = range_bad | (|mismatch);
endmodule

// File: rtl/vafc_region_rules.sv
module vafc_region_rules
  import vafc_pkg::*;
(
  input  logic       [1:0] el,
  input  logic             region,
  input  logic             addr_bad,
  input  logic             host_ext,
  input  logic             t0_walk_off,
  input  logic             t1_walk_off,
  input  logic             t0_hier_off,
  input  logic             t1_hier_off,
  input  logic             hier_off,
  input  logic       [1:0] t0_inner,
  input  logic       [1:0] t1_inner,
  input  logic       [1:0] t0_gran,
  input  logic       [1:0] t1_gran,
  output vafc_rsp_t        rsp
);
  always_comb begin
    rsp.region   = region;
    rsp.gran     = region ? t1_gran : t0_gran;
    rsp.uncached = region ? (t1_inner == 2'd0) : (t0_inner == 2'd0);
    rsp.hier_off = region ? t1_hier_off : t0_hier_off;
    rsp.fault    = addr_bad;
    unique case (el)
      2'd0, 2'd1: begin
        rsp.fault = addr_bad | (region ? t1_walk_off : t0_walk_off);
      end
      2'd2: begin
        if (region) begin
          rsp.fault = addr_bad | ~host_ext | t1_walk_off;
        end else begin
          rsp.fault    = addr_bad | (host_ext & t0_walk_off);
          rsp.hier_off = host_ext ? t0_hier_off : hier_off;
        end
      end
      default: begin
        if (region) begin
          rsp.fault    = 1'b1;
          rsp.gran     = 2'd0;
          rsp.hier_off = 1'b0;
          rsp.uncached = 1'b0;
        end else begin
          rsp.hier_off = hier_off;
        end
      end
    endcase
  end
endmodule

// File: rtl/va_range_checker.sv
module va_range_checker
  import vafc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_vaddr,
  input  logic [1:0]  req_el,
  input  logic [5:0]  req_top_bit,
  input  logic [5:0]  t0_size,
  input  logic [5:0]  t1_size,
  input  logic [1:0]  t0_gran,
  input  logic [1:0]  t1_gran,
  input  logic        t0_walk_off,
  input  logic        t1_walk_off,
  input  logic        t0_hier_off,
  input  logic        t1_hier_off,
  input  logic        hier_off,
  input  logic [1:0]  t0_inner,
  input  logic [1:0]  t1_inner,
  input  logic        host_ext,
  input  logic        large_va,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic        rsp_region,
  output logic [1:0]  rsp_gran,
  output logic        rsp_hier_off,
  output logic        rsp_uncached
);
  logic       region_sel;
  logic       addr_bad;
  vafc_rsp_t  rule_rsp;
  vafc_rsp_t  rsp_d, rsp_q;
  logic       valid_d, valid_q;

  assign region_sel = req_vaddr[req_top_bit];

  vafc_size_check #(.ADDR_W(VA_W)) size_i (
    .vaddr      (req_vaddr),
    .top_bit    (req_top_bit),
    .size_field (region_sel ? t1_size : t0_size),
    .gran       (region_sel ? t1_gran : t0_gran),
    .large_va   (large_va),
    .upper      (region_sel),
    .addr_bad   (addr_bad)
  );

  vafc_region_rules rules_i (
    .el          (req_el),
    .region      (region_sel),
    .addr_bad    (addr_bad),
    .host_ext    (host_ext),
    .t0_walk_off (t0_walk_off),
    .t1_walk_off (t1_walk_off),
    .t0_hier_off (t0_hier_off),
    .t1_hier_off (t1_hier_off),
    .hier_off    (hier_off),
    .t0_inner    (t0_inner),
    .t1_inner    (t1_inner),
    .t0_gran     (t0_gran),
    .t1_gran     (t1_gran),
    .rsp         (rule_rsp)
  );

  always_comb begin
    valid_d = req_valid;
    rsp_d   = rsp_q;
    if (req_valid) rsp_d = rule_rsp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      valid_q <= valid_d;
      rsp_q   <= rsp_d;
    end
  end

  assign rsp_valid    = valid_q;
  assign rsp_fault    = rsp_q.fault;
  assign rsp_region   = rsp_q.region;
  assign rsp_gran     = rsp_q.gran;
  assign rsp_hier_off = rsp_q.hier_off;
  assign rsp_uncached = rsp_q.uncached;

  // R9
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable({rsp_fault, rsp_region, rsp_gran, rsp_hier_off, rsp_uncached})));
  // R1
  region_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_region == $past(req_vaddr[req_top_bit]));
  // R4
  walk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_el[1] && (req_vaddr[req_top_bit] ? t1_walk_off : t0_walk_off)) |=> rsp_fault);
  // R5
  el2_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_el == 2'd2 && !host_ext && req_vaddr[req_top_bit]) |=> rsp_fault);
  // R7
  el3_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_el == 2'd3 && req_vaddr[req_top_bit]) |=> (rsp_fault && rsp_gran == 2'd0 && !rsp_uncached));
endmodule

// File: tb/va_range_checker_tb_top.sv
`timescale 1ns/1ps
module va_range_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_vaddr;
  logic [1:0]  req_el;
  logic [5:0]  req_top_bit;
  logic [5:0]  t0_size, t1_size;
  logic [1:0]  t0_gran, t1_gran;
  logic        t0_walk_off, t1_walk_off;
  logic        t0_hier_off, t1_hier_off, hier_off;
  logic [1:0]  t0_inner, t1_inner;
  logic        host_ext, large_va;
  logic        rsp_valid, rsp_fault, rsp_region, rsp_hier_off, rsp_uncached;
  logic [1:0]  rsp_gran;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  va_range_checker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_el(req_el), .req_top_bit(req_top_bit), .t0_size(t0_size), .t1_size(t1_size),
    .t0_gran(t0_gran), .t1_gran(t1_gran), .t0_walk_off(t0_walk_off),
    .t1_walk_off(t1_walk_off), .t0_hier_off(t0_hier_off), .t1_hier_off(t1_hier_off),
    .hier_off(hier_off), .t0_inner(t0_inner), .t1_inner(t1_inner),
    .host_ext(host_ext), .large_va(large_va), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_region(rsp_region), .rsp_gran(rsp_gran),
    .rsp_hier_off(rsp_hier_off), .rsp_uncached(rsp_uncached)
  );

  // expected {fault, region, gran[1:0], hier_off, uncached} from the requirements
  function automatic logic [5:0] model();
    logic       rg;
    int         sz, mx, mn;
    logic [1:0] g;
    logic       bad, f, h, u;
    rg  = req_vaddr[req_top_bit];
    sz  = 64 - int'(rg ? t1_size : t0_size);
    g   = rg ? t1_gran : t0_gran;
    mx  = (large_va && g == 2'd2) ? 52 : 48;
    mn  = (g == 2'd2) ? 17 : 16;
    bad = (sz > mx) || (sz < mn);
    for (int b = 0; b < 64; b++)
      if (b >= sz && b <= int'(req_top_bit) && req_vaddr[b] != rg) bad = 1'b1;
    h = rg ? t1_hier_off : t0_hier_off;
    u = rg ? (t1_inner == 2'd0) : (t0_inner == 2'd0);
    f = bad;
    case (req_el)
      2'd0, 2'd1: f = bad || (rg ? t1_walk_off : t0_walk_off);
      2'd2: begin
        if (rg) f = bad || !host_ext || t1_walk_off;
        else begin
          f = bad || (host_ext && t0_walk_off);
          h = host_ext ? t0_hier_off : hier_off;
        end
      end
      default: begin
        if (rg) begin f = 1'b1; g = 2'd0; h = 1'b0; u = 1'b0; end
        else h = hier_off;
      end
    endcase
    return {f, rg, g, h, u};
  endfunction

  function automatic logic [5:0] actual();
    return {rsp_fault, rsp_region, rsp_gran, rsp_hier_off, rsp_uncached};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (el=%0d top=%0d va=%h)",
               req, act, exp, req_el, req_top_bit, req_vaddr);
    end
  endtask

  task automatic defaults();
    req_valid = 0; req_vaddr = '0; req_el = 2'd1; req_top_bit = 6'd63;
    t0_size = 6'd16; t1_size = 6'd16; t0_gran = 2'd0; t1_gran = 2'd0;
    t0_walk_off = 0; t1_walk_off = 0; t0_hier_off = 0; t1_hier_off = 0; hier_off = 0;
    t0_inner = 2'd1; t1_inner = 2'd1; host_ext = 0; large_va = 0;
  endtask

  // inputs set by caller before this; pulse one request, sample after the edge
  task automatic issue(input string req);
    logic [5:0] exp;
    @(negedge clk);
    req_valid = 1;
    exp = model();
    @(negedge clk);
    req_valid = 0;
    check({req, " R9 valid"}, {5'd0, rsp_valid}, 6'd1);
    check(req, actual(), exp);
  endtask

  task automatic t_reset();
    check("R9 reset", {actual()[5:0]}, 6'd0);
    check("R9 reset valid", {5'd0, rsp_valid}, 6'd0);
  endtask

  task automatic t_size_sweep();
    int sizes[10] = '{15, 16, 17, 18, 47, 48, 49, 51, 52, 53};
    for (int el = 0; el < 4; el++)
      for (int g = 0; g < 3; g++)
        for (int lv = 0; lv < 2; lv++)
          for (int k = 0; k < 10; k++)
            for (int up = 0; up < 2; up++) begin
              defaults();
              host_ext = 1; req_el = 2'(el); large_va = lv[0];
              t0_gran = 2'(g); t1_gran = 2'(g);
              t0_size = 6'(64 - sizes[k]); t1_size = 6'(64 - sizes[k]);
              req_vaddr = up ? '1 : '0;
              issue("R2 size limit");
            end
  endtask

  task automatic t_sign_ext();
    defaults();
    req_el = 2'd0; t0_size = 6'd16; t1_size = 6'd16;
    req_top_bit = 6'd55; req_vaddr = 64'h1000_0000_0000_0000;
    issue("R3 top55 lower tag ignored");
    check("R3 no fault", {5'd0, rsp_fault}, 6'd0);
    req_top_bit = 6'd63;
    issue("R3 top63 lower bit60");
    check("R3 fault", {5'd0, rsp_fault}, 6'd1);
    req_top_bit = 6'd55; req_vaddr = 64'h00FF_FF00_0000_0000;
    issue("R3 top55 upper ok");
    check("R3 R1 upper ok", {4'd0, rsp_region, rsp_fault}, 6'b10);
    req_vaddr = 64'h00FE_FF00_0000_0000;
    issue("R3 top55 upper hole");
    check("R3 upper hole fault", {5'd0, rsp_fault}, 6'd1);
    req_vaddr = 64'h0001_0000_0000_0000;
    issue("R3 lower bit48 set");
  endtask

  task automatic t_walk_off();
    for (int el = 0; el < 4; el++)
      for (int e2 = 0; e2 < 2; e2++)
        for (int w = 0; w < 4; w++)
          for (int up = 0; up < 2; up++) begin
            defaults();
            req_el = 2'(el); host_ext = e2[0];
            t0_walk_off = w[0]; t1_walk_off = w[1];
            t0_hier_off = 1; t1_hier_off = 0; hier_off = up[0];
            t0_inner = 2'(w); t1_inner = 2'(3 - w);
            t0_gran = 2'd1; t1_gran = 2'd2;
            req_vaddr = up ? 64'hFFFF_0000_0000_1234 : 64'h0000_0000_0000_1234;
            issue(el < 2 ? "R4 walk off" : (el == 2 ? "R5 R6 el2 rules" : "R7 el3 rules"));
          end
  endtask

  task automatic t_el_direct();
    defaults();
    req_el = 2'd3; req_vaddr = '1; t1_inner = 2'd0; t1_gran = 2'd2; t1_hier_off = 1;
    issue("R7 el3 upper");
    check("R7 el3 upper exact", actual(), 6'b110000);
    req_el = 2'd2; host_ext = 0; req_vaddr = '0; t0_hier_off = 1; hier_off = 0;
    t0_walk_off = 1; t0_inner = 2'd0; t0_gran = 2'd1;
    issue("R6 el2 no host");
    check("R5 R6 R8 el2 lower exact", actual(), 6'b000101);
  endtask

  task automatic t_hold();
    logic [5:0] prev;
    defaults();
    req_el = 2'd0; t0_walk_off = 1; t0_gran = 2'd2; t0_inner = 2'd0; t0_size = 6'd20;
    issue("R9 setup");
    prev = actual();
    req_vaddr = '1; t0_walk_off = 0; t1_gran = 2'd1; req_el = 2'd3;
    @(negedge clk);
    check("R9 hold valid low", {5'd0, rsp_valid}, 6'd0);
    check("R9 hold value", actual(), prev);
  endtask

  initial begin
    defaults();
    rst_n = 0;
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_size_sweep();
    t_sign_ext();
    t_walk_off();
    t_el_direct();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule